// File: doc/BRIEF.md
# Serial Peripheral Controller Register Bank

This block is the software-visible register bank of a serial peripheral controller. A processor reaches it over a simple 16-bit bus made of a byte offset, an access-size code, separate write and read strobes, write data and read data. It holds seven 16-bit registers: control, chip-select flags, status, transmit data, receive data, bit-rate divisor and a receive shadow copy. The bank keeps the transfer status flags current as software writes the transmit register or reads the receive register. The effect of each access depends on the enable bit and on the transfer-start mode held in control.

Status flags are write-one-to-clear. An illegal access is ignored and reported on a one-cycle error output. An access is illegal when its size is not 16 bits, when its offset maps to no register, or when it asserts both strobes together. The serial shifter, the bit clock, DMA and interrupt routing are not part of this block. They sit around it and use the register values it holds.

Top module: `spi_regbank`

## Requirements
- R1: After reset, control reads 0x0400, flags read 0xFF00 and status reads 0x0001. Transmit, receive, divisor and shadow read 0x0000.
- R2: Registers sit at byte offsets 0, 4, 8, 12, 16, 20 and 24 in the order control, flags, status, transmit, receive, divisor, shadow. Read data appears on `bus_rdata` in the cycle after the read strobe, and is 0 in cycles without a legal read.
- R3: A legal write to control, flags, divisor, shadow, receive or transmit stores all 16 bits, and a later read returns them.
- R4: A write to status clears bit 0 (transfer done), bit 3 (transmit full) and bit 5 (receive full) wherever the written bit is 1. Those bits are left unchanged where the written bit is 0. All other status bits ignore the write and read as 0.
- R5: A write to transmit while control bit 14 (enable) is 1 and control bits [1:0] are 01 (start on transmit write) sets status bit 5 and clears status bit 3 at the clock edge of the write.
- R6: A read of receive while enable is 1 and control bits [1:0] are 00 (start on receive read) returns the stored value and clears status bits 5 and 3 at the clock edge of the read.
- R7: With enable 0, or with a mode other than the one named in R5 or R6, transmit writes and receive reads leave status unchanged.
- R8: `bus_size` encodes 00 as 8-bit, 01 as 16-bit, 10 as 32-bit and 11 as reserved. Only 01 is legal. Any other size raises `bus_err` for exactly one cycle after the access and changes no register.
- R9: An offset with bits [1:0] not zero, or an offset of 28 or above, raises `bus_err` and changes no register. An errored read returns 0.
- R10: Asserting `bus_wr` and `bus_rd` in the same cycle is an error: `bus_err` rises and no register changes.
- R11: Status bit 0 is never set by any access. After reset it can only be cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (5) | Byte offset of the access |
| bus_size | input | 2 | Access size code (01 = 16-bit) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| bus_err | output | 1 | One-cycle illegal-access indication |

## Verification
A wrong status flag cannot be observed directly. It becomes visible on `bus_rdata` at the first status read after the access that corrupted it, which is one cycle after that read is issued. For this reason the bench reads status right after every buffer access and every mode change. A decode fault shows at once: `bus_err` asserts, or fails to assert, in the cycle after the access. A wrongly latched write shows up later, when the overwritten register is read back. The bench reads back the register an illegal write targeted.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;

    localparam int REG_W  = 16;
    localparam int NREG   = 7;

    // register index = byte offset / 4
    localparam int IDX_CTRL = 0;
    localparam int IDX_SEL  = 1;
    localparam int IDX_STAT = 2;
    localparam int IDX_TX   = 3;
    localparam int IDX_RX   = 4;
    localparam int IDX_DIV  = 5;
    localparam int IDX_SHAD = 6;

    localparam int EN_BIT   = 14;
    localparam int DONE_BIT = 0;
    localparam int TXF_BIT  = 3;
    localparam int RXF_BIT  = 5;

    localparam logic [1:0] MODE_RX_READ  = 2'b00;
    localparam logic [1:0] MODE_TX_WRITE = 2'b01;
    localparam logic [1:0] SIZE_HALF     = 2'b01;

    localparam logic [REG_W-1:0] W1C_MASK =
        REG_W'((1 << DONE_BIT) | (1 << TXF_BIT) | (1 << RXF_BIT));

    typedef struct packed {
        logic [NREG-1:0][REG_W-1:0] regs;
        logic [REG_W-1:0]           rdata;
        logic                       err;
    } bank_t;

    function automatic bank_t bank_reset();
        bank_t b;
        b = '0;
        b.regs[IDX_CTRL] = 16'h0400;
        b.regs[IDX_SEL]  = 16'hFF00;
        b.regs[IDX_STAT] = 16'h0001;
        return b;
    endfunction

endpackage

// File: rtl/spi_regbank_decode.sv
module spi_regbank_decode #(
    parameter int ADDR_W = 5,
    parameter int NREG   = 7,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              wr,
    input  logic              rd,
    output logic              hit,
    output logic              bad,
    output logic [IDX_W-1:0]  idx
);
    import spi_regbank_pkg::*;

    logic access;
    logic legal;

    always_comb begin
        idx    = addr[ADDR_W-1:2];
        access = wr | rd;
        legal  = (size == SIZE_HALF)
               && (addr[1:0] == 2'b00)
               && (int'(idx) < NREG)
               && !(wr && rd);
        hit    = access && legal;
        bad    = access && !legal;
    end

endmodule

// File: rtl/spi_regbank_status.sv
module spi_regbank_status (
    input  logic [15:0] stat_q,
    input  logic [15:0] ctrl_q,
    input  logic        w1c,
    input  logic        tx_wr,
    input  logic        rx_rd,
    input  logic [15:0] wdata,
    output logic [15:0] stat_d
);
    import spi_regbank_pkg::*;

    logic       en;
    logic [1:0] mode;

    always_comb begin
        en     = ctrl_q[EN_BIT];
        mode   = ctrl_q[1:0];
        stat_d = stat_q;
        if (w1c) begin
            stat_d = stat_q & ~(wdata & W1C_MASK);
        end else if (tx_wr && en && mode == MODE_TX_WRITE) begin
            stat_d[RXF_BIT] = 1'b1;
            stat_d[TXF_BIT] = 1'b0;
        end else if (rx_rd && en && mode == MODE_RX_READ) begin
            stat_d[RXF_BIT] = 1'b0;
            stat_d[TXF_BIT] = 1'b0;
        end
    end

endmodule

// File: rtl/spi_regbank.sv
module spi_regbank #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              bus_err
);
    import spi_regbank_pkg::*;

    localparam int IDX_W = ADDR_W - 2;

    bank_t s_d, s_q;

    logic             hit, bad;
    logic [IDX_W-1:0] idx;
    logic             w1c, tx_wr, rx_rd;
    logic [15:0]      stat_nx;

    spi_regbank_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
        .addr (bus_addr),
        .size (bus_size),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .hit  (hit),
        .bad  (bad),
        .idx  (idx)
    );

    always_comb begin
        w1c   = hit && bus_wr && (int'(idx) == IDX_STAT);
        tx_wr = hit && bus_wr && (int'(idx) == IDX_TX);
        rx_rd = hit && bus_rd && (int'(idx) == IDX_RX);
    end

    spi_regbank_status u_stat (
        .stat_q (s_q.regs[IDX_STAT]),
        .ctrl_q (s_q.regs[IDX_CTRL]),
        .w1c    (w1c),
        .tx_wr  (tx_wr),
        .rx_rd  (rx_rd),
        .wdata  (bus_wdata),
        .stat_d (stat_nx)
    );

    always_comb begin
        s_d       = s_q;
        s_d.rdata = '0;
        s_d.err   = bad;
        for (int i = 0; i < NREG; i++) begin
            if (i != IDX_STAT && hit && bus_wr && int'(idx) == i) begin
                s_d.regs[i] = bus_wdata;
            end
            if (hit && bus_rd && int'(idx) == i) begin
                s_d.rdata = s_q.regs[i];
            end
        end
        s_d.regs[IDX_STAT] = stat_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= bank_reset();
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata = s_q.rdata;
    assign bus_err   = s_q.err;

endmodule

// File: rtl/spi_regbank_chk.sv
module spi_regbank_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [15:0]       bus_rdata,
    input logic              bus_err,
    input logic [15:0]       ctrl,
    input logic [15:0]       stat
);
    logic tx_legal_wr, rx_legal_rd;
    assign tx_legal_wr = bus_wr && !bus_rd && bus_size == 2'b01 && bus_addr == ADDR_W'(12);
    assign rx_legal_rd = bus_rd && !bus_wr && bus_size == 2'b01 && bus_addr == ADDR_W'(16);

    // R5
    tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_legal_wr && ctrl[14] && ctrl[1:0] == 2'b01) |=> (stat[5] && !stat[3]));

    // R6
    rx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_legal_rd && ctrl[14] && ctrl[1:0] == 2'b00) |=> (!stat[5] && !stat[3]));

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_wr || bus_rd));

    // R9
    err_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> ($stable(ctrl) && $stable(stat)));

    // R9
    err_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_rdata == 16'h0000);

    // R10
    dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_rd) |=> bus_err);

    // R11
    done_never_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(stat[0]));

endmodule

bind spi_regbank spi_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .ctrl      (s_q.regs[0]),
    .stat      (s_q.regs[2])
);

// File: tb/sim_spi_regbank.sv
module sim_spi_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'b01;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    spi_regbank #(.ADDR_W(5)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [4:0]  addr;
        logic [1:0]  size;
        logic [15:0] wd;
        logic [15:0] exp;
        logic        eerr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 44;
    localparam vec_t VEC [NV] = '{
        // R1 reset values
        '{1'b0,1'b1,5'd0, 2'd1,16'h0000,16'h0400,1'b0,4'd1},
        '{1'b0,1'b1,5'd4, 2'd1,16'h0000,16'hFF00,1'b0,4'd1},
        '{1'b0,1'b1,5'd8, 2'd1,16'h0000,16'h0001,1'b0,4'd1},
        '{1'b0,1'b1,5'd12,2'd1,16'h0000,16'h0000,1'b0,4'd1},
        '{1'b0,1'b1,5'd16,2'd1,16'h0000,16'h0000,1'b0,4'd1},
        '{1'b0,1'b1,5'd20,2'd1,16'h0000,16'h0000,1'b0,4'd1},
        '{1'b0,1'b1,5'd24,2'd1,16'h0000,16'h0000,1'b0,4'd1},
        // R3 / R2 plain storage and map
        '{1'b1,1'b0,5'd20,2'd1,16'h1234,16'h0000,1'b0,4'd3},
        '{1'b0,1'b1,5'd20,2'd1,16'h0000,16'h1234,1'b0,4'd2},
        '{1'b1,1'b0,5'd24,2'd1,16'hABCD,16'h0000,1'b0,4'd3},
        '{1'b0,1'b1,5'd24,2'd1,16'h0000,16'hABCD,1'b0,4'd2},
        '{1'b1,1'b0,5'd4, 2'd1,16'h00A5,16'h0000,1'b0,4'd3},
        '{1'b0,1'b1,5'd4, 2'd1,16'h0000,16'h00A5,1'b0,4'd3},
        '{1'b1,1'b0,5'd16,2'd1,16'h5A5A,16'h0000,1'b0,4'd3},
        // R7 disabled buffer accesses
        '{1'b0,1'b1,5'd16,2'd1,16'h0000,16'h5A5A,1'b0,4'd7},
        '{1'b1,1'b0,5'd12,2'd1,16'h1111,16'h0000,1'b0,4'd7},
        '{1'b0,1'b1,5'd8, 2'd1,16'h0000,16'h0001,1'b0,4'd7},
        // enable, mode 01
        '{1'b1,1'b0,5'd0, 2'd1,16'h4001,16'h0000,1'b0,4'd3},
        '{1'b0,1'b1,5'd0, 2'd1,16'h0000,16'h4001,1'b0,4'd3},
        // R5
        '{1'b1,1'b0,5'd12,2'd1,16'h2222,16'h0000,1'b0,4'd5},
        '{1'b0,1'b1,5'd8, 2'd1,16'h0000,16'h0021,1'b0,4'd5},
        '{1'b0,1'b1,5'd12,2'd1,16'h0000,16'h2222,1'b0,4'd3},
        // R4 clear all
        '{1'b1,1'b0,5'd8, 2'd1,16'hFFFF,16'h0000,1'b0,4'd4},
        '{1'b0,1'b1,5'd8, 2'd1,16'h0000,16'h0000,1'b0,4'd4},
        '{1'b1,1'b0,5'd12,2'd1,16'h3333,16'h0000,1'b0,4'd5},
        '{1'b0,1'b1,5'd8, 2'd1,16'h0000,16'h0020,1'b0,4'd5},
        // R7 receive read in mode 01
        '{1'b0,1'b1,5'd16,2'd1,16'h0000,16'h5A5A,1'b0,4'd7},
        '{1'b0,1'b1,5'd8, 2'd1,16'h0000,16'h0020,1'b0,4'd7},
        // R4 partial clear leaves bit 5
        '{1'b1,1'b0,5'd8, 2'd1,16'h0008,16'h0000,1'b0,4'd4},
        '{1'b0,1'b1,5'd8, 2'd1,16'h0000,16'h0020,1'b0,4'd4},
        // R6 mode 00
        '{1'b1,1'b0,5'd0, 2'd1,16'h4000,16'h0000,1'b0,4'd6},
        '{1'b0,1'b1,5'd16,2'd1,16'h0000,16'h5A5A,1'b0,4'd6},
        '{1'b0,1'b1,5'd8, 2'd1,16'h0000,16'h0000,1'b0,4'd6},
        // R8 bad size
        '{1'b1,1'b0,5'd0, 2'd0,16'h0000,16'h0000,1'b1,4'd8},
        '{1'b0,1'b1,5'd0, 2'd1,16'h0000,16'h4000,1'b0,4'd8},
        '{1'b0,1'b1,5'd8, 2'd2,16'h0000,16'h0000,1'b1,4'd8},
        // R9 unmapped / misaligned
        '{1'b0,1'b1,5'd28,2'd1,16'h0000,16'h0000,1'b1,4'd9},
        '{1'b1,1'b0,5'd13,2'd1,16'hFFFF,16'h0000,1'b1,4'd9},
        '{1'b0,1'b1,5'd12,2'd1,16'h0000,16'h3333,1'b0,4'd9},
        // R10 both strobes
        '{1'b1,1'b1,5'd0, 2'd1,16'h0000,16'h0000,1'b1,4'd10},
        '{1'b0,1'b1,5'd0, 2'd1,16'h0000,16'h4000,1'b0,4'd10},
        // R7 disabled with mode 01
        '{1'b1,1'b0,5'd0, 2'd1,16'h0001,16'h0000,1'b0,4'd7},
        '{1'b1,1'b0,5'd12,2'd1,16'h7777,16'h0000,1'b0,4'd7},
        '{1'b0,1'b1,5'd8, 2'd1,16'h0000,16'h0000,1'b0,4'd7}
    };

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input int req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic rd, input logic [4:0] a,
                       input logic [1:0] sz, input logic [15:0] wd,
                       input logic [15:0] exp, input logic eerr, input int req);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_size = sz; bus_wdata = wd;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check(bus_rdata, exp, req);
        check({15'd0, bus_err}, {15'd0, eerr}, req);
    endtask

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 outputs idle during reset
        check(bus_rdata, 16'h0000, 1);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            acc(VEC[i].wr, VEC[i].rd, VEC[i].addr, VEC[i].size,
                VEC[i].wd, VEC[i].exp, VEC[i].eerr, int'(VEC[i].req));
        end

        // R8 error lasts one cycle
        acc(1'b0, 1'b1, 5'd8, 2'd3, 16'h0, 16'h0, 1'b1, 8);
        @(negedge clk);
        check({15'd0, bus_err}, 16'h0000, 8);

        // R2 no read -> rdata zero
        check(bus_rdata, 16'h0000, 2);

        // reset again, R1
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        acc(1'b0, 1'b1, 5'd0, 2'd1, 16'h0, 16'h0400, 1'b0, 1);
        acc(1'b0, 1'b1, 5'd12, 2'd1, 16'h0, 16'h0000, 1'b0, 1);

        // R4 writing 0 to bit 0 keeps done flag
        acc(1'b1, 1'b0, 5'd8, 2'd1, 16'h0020, 16'h0, 1'b0, 4);
        acc(1'b0, 1'b1, 5'd8, 2'd1, 16'h0, 16'h0001, 1'b0, 4);
        // R11 done flag clears and stays clear
        acc(1'b1, 1'b0, 5'd8, 2'd1, 16'h0001, 16'h0, 1'b0, 11);
        acc(1'b1, 1'b0, 5'd0, 2'd1, 16'h4001, 16'h0, 1'b0, 11);
        acc(1'b1, 1'b0, 5'd12, 2'd1, 16'h0101, 16'h0, 1'b0, 11);
        acc(1'b0, 1'b1, 5'd8, 2'd1, 16'h0, 16'h0020, 1'b0, 11);
        acc(1'b1, 1'b0, 5'd8, 2'd1, 16'hFFDE, 16'h0, 1'b0, 11);
        acc(1'b0, 1'b1, 5'd8, 2'd1, 16'h0, 16'h0020, 1'b0, 4);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule